// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block drives the multiplexed address bus of a DRAM array. When an access opens it captures a row and a column address and presents the row first, then the column. When a refresh is in progress it presents a refresh row from an internal counter in place of either. A small state machine tracks the access phase. Separate logic, outside this block, produces the row-phase, column-phase and RAS-release strobes and the refresh-busy flag. This block only decides which value the bus carries.

The column step input has two meanings. During an access it advances the captured column by one, for burst transfers. The column wraps inside its own field and never carries into the row. During a refresh it stretches the refresh, and the column is left untouched. A refresh that interrupts an access returns the machine to the phase it left, so the access resumes with the same captured addresses.

With the pipelining mode bit set, the bus returns from the column to the row once the column hold time of `HOLD_CYC` clocks has passed, which is one clock by default. The next column phase of a burst can then follow. With the bit clear, the column stays on the bus until the RAS-release strobe closes the access.

The states are these:
- S_IDLE: no access is open, and the bus shows the last captured row.
- S_ROW: the row phase, with the row on the bus.
- S_COL: the column phase, with the column on the bus.
- S_REROW: the pipelined return, with the row on the bus again.
- S_RFSH: a refresh, with the refresh row on the bus.

The transitions are these:
- S_IDLE→S_ROW on a row-phase strobe.
- S_ROW→S_COL and S_REROW→S_COL on a column-phase strobe.
- S_COL→S_REROW in pipelined mode once the hold count expires.
- S_ROW, S_COL or S_REROW→S_IDLE on a RAS-release strobe.
- Any state→S_RFSH while refresh-busy is high.
- S_RFSH→the saved state once refresh-busy and the step input are both low.

Top module: `dram_addr_mux`

## Requirements
- R1: After reset the bus reads 0, the machine is in S_IDLE and the refresh row counter is 0.
- R2: A row-phase strobe in S_IDLE, with no refresh, captures the row and column inputs, and the bus carries the captured row (zero-extended) from the next clock edge.
- R3: A column-phase strobe in S_ROW or S_REROW makes the bus carry the captured column (zero-extended) from the next clock edge.
- R4: While the machine is in S_RFSH, which it enters on the edge after refresh-busy is sampled high, the bus carries the refresh row counter.
- R5: The refresh row counter increases by one on the edge that ends each refresh and wraps modulo 2^ROW_W.
- R6: The step input, sampled high in S_ROW, S_COL or S_REROW with no refresh, adds one to the captured column modulo 2^COL_W and leaves the captured row unchanged.
- R7: The step input, sampled high in S_RFSH, keeps the machine in refresh even after refresh-busy falls and leaves the captured column unchanged.
- R8: In pipelined mode the column stays on the bus for exactly HOLD_CYC clocks, after which the bus carries the captured row again.
- R9: In non-pipelined mode the column stays on the bus until a RAS-release strobe.
- R10: A RAS-release strobe in any access state, with no refresh, returns the machine to S_IDLE, and the bus then carries the captured row.
- R11: Refresh-busy takes priority over a simultaneous row-phase strobe. No access opens, and after the refresh the bus carries the previously captured row.
- R12: A refresh that interrupts an access returns to the interrupted state, and the bus again shows that state's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_in | input | ROW_W | Row address to capture |
| col_in | input | COL_W | Column address to capture |
| row_phase | input | 1 | Opens an access (row phase) |
| col_phase | input | 1 | Starts a column phase |
| ras_release | input | 1 | Access RAS lines negate; closes the access |
| refresh_busy | input | 1 | Refresh in progress |
| col_step | input | 1 | Column increment, or refresh extend during refresh |
| pipe_mode | input | 1 | 1 = pipelined return to row after the column hold |
| dram_addr | output | ADDR_W | Multiplexed DRAM address bus, ADDR_W = max(ROW_W, COL_W) |

## Verification
All state and latches are registered and the bus is decoded straight from them. Each result is therefore due one rising edge after the stimulus is sampled. The one exception is the pipelined return, which comes HOLD_CYC edges after the column appears. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares the bus at the next falling edge. The expected value comes from its own copy of the captured row, the captured column and the refresh count, all kept in modular arithmetic.

// File: rtl/dam_pkg.sv
package dam_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ROW   = 3'd1,
        S_COL   = 3'd2,
        S_REROW = 3'd3,
        S_RFSH  = 3'd4
    } dam_state_e;

    function automatic logic in_access(input dam_state_e s);
        return (s == S_ROW) || (s == S_COL) || (s == S_REROW);
    endfunction
endpackage

// File: rtl/dam_addr_latch.sv
module dam_addr_latch #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [ROW_W-1:0] row_d,
    input  logic [COL_W-1:0] col_d,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= row_d;
            col_q <= col_d;
        end else if (step) begin
            // The increment stays inside the column field.
            col_q <= col_q + ONE;
        end
    end
endmodule

// File: rtl/dam_rfsh_ctr.sv
module dam_rfsh_ctr #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] rfsh_row
);
    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            rfsh_row <= '0;
        else if (advance)
            rfsh_row <= rfsh_row + ONE;
    end
endmodule

// File: rtl/dam_hold_timer.sv
module dam_hold_timer #(
    parameter int HOLD_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && cnt != LAST)
            cnt <= cnt + CW'(1);
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/dam_fsm.sv
module dam_fsm
    import dam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       row_phase,
    input  logic       col_phase,
    input  logic       ras_release,
    input  logic       refresh_busy,
    input  logic       col_step,
    input  logic       pipe_mode,
    input  logic       hold_done,
    output dam_state_e st_q,
    output logic       latch_en,
    output logic       col_inc,
    output logic       rfsh_done,
    output logic       hold_clr
);
    dam_state_e st_nxt;
    dam_state_e resume_q;
    dam_state_e resume_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            resume_q <= S_IDLE;
        end else begin
            st_q     <= st_nxt;
            resume_q <= resume_nxt;
        end
    end

    always_comb begin
        st_nxt     = st_q;
        resume_nxt = resume_q;
        latch_en   = 1'b0;
        rfsh_done  = 1'b0;
        if (st_q == S_RFSH) begin
            // The step input stretches the refresh.
            if (!refresh_busy && !col_step) begin
                st_nxt    = resume_q;
                rfsh_done = 1'b1;
            end
        end else if (refresh_busy) begin
            st_nxt     = S_RFSH;
            resume_nxt = st_q;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (row_phase) begin
                        st_nxt   = S_ROW;
                        latch_en = 1'b1;
                    end
                end
                S_ROW: begin
                    if (ras_release)    st_nxt = S_IDLE;
                    else if (col_phase) st_nxt = S_COL;
                end
                S_COL: begin
                    if (ras_release)                 st_nxt = S_IDLE;
                    else if (pipe_mode && hold_done) st_nxt = S_REROW;
                end
                S_REROW: begin
                    if (ras_release)    st_nxt = S_IDLE;
                    else if (col_phase) st_nxt = S_COL;
                end
                default: st_nxt = S_IDLE;
            endcase
        end
    end

    assign col_inc  = col_step && !refresh_busy && in_access(st_q);
    assign hold_clr = (st_nxt == S_COL) && (st_q != S_COL);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dam_pkg::*;
#(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 4,
    parameter int HOLD_CYC = 1,
    parameter int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic              row_phase,
    input  logic              col_phase,
    input  logic              ras_release,
    input  logic              refresh_busy,
    input  logic              col_step,
    input  logic              pipe_mode,
    output logic [ADDR_W-1:0] dram_addr
);
    dam_state_e       st_cur;
    logic             latch_en;
    logic             col_inc;
    logic             rfsh_done;
    logic             hold_clr;
    logic             hold_done;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] rfsh_row;

    dam_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_phase    (row_phase),
        .col_phase    (col_phase),
        .ras_release  (ras_release),
        .refresh_busy (refresh_busy),
        .col_step     (col_step),
        .pipe_mode    (pipe_mode),
        .hold_done    (hold_done),
        .st_q         (st_cur),
        .latch_en     (latch_en),
        .col_inc      (col_inc),
        .rfsh_done    (rfsh_done),
        .hold_clr     (hold_clr)
    );

    dam_addr_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_en),
        .step  (col_inc),
        .row_d (row_in),
        .col_d (col_in),
        .row_q (row_q),
        .col_q (col_q)
    );

    dam_rfsh_ctr #(.ROW_W(ROW_W)) u_rctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (rfsh_done),
        .rfsh_row (rfsh_row)
    );

    dam_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_clr),
        .run   (st_cur == S_COL),
        .done  (hold_done)
    );

    // The bus is decoded from the registered state alone.
    always_comb begin
        unique case (st_cur)
            S_COL:   dram_addr = ADDR_W'(col_q);
            S_RFSH:  dram_addr = ADDR_W'(rfsh_row);
            default: dram_addr = ADDR_W'(row_q);
        endcase
    end
endmodule

// File: rtl/dam_checker.sv
module dam_checker
    import dam_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROW_W-1:0]  row_in,
    input logic              row_phase,
    input logic              col_phase,
    input logic              ras_release,
    input logic              refresh_busy,
    input logic              col_step,
    input logic              pipe_mode,
    input logic              hold_done,
    input dam_state_e        st,
    input logic [ROW_W-1:0]  row_q,
    input logic [COL_W-1:0]  col_q,
    input logic [ROW_W-1:0]  rfsh_row,
    input logic [ADDR_W-1:0] dram_addr
);
    p_row_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && row_phase && !refresh_busy) |=> dram_addr == ADDR_W'($past(row_in)));

    p_col_show_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_ROW || st == S_REROW) && col_phase && !ras_release && !refresh_busy)
            |=> dram_addr == ADDR_W'(col_q));

    p_rfsh_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |=> dram_addr == ADDR_W'(rfsh_row));

    p_rfsh_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RFSH && !refresh_busy && !col_step) |=> rfsh_row == $past(rfsh_row) + ROW_W'(1));

    p_col_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_ROW || st == S_COL || st == S_REROW) && col_step && !refresh_busy)
            |=> (col_q == $past(col_q) + COL_W'(1)) && $stable(row_q));

    p_extend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RFSH && col_step) |=> (st == S_RFSH) && $stable(col_q));

    p_pipe_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_COL && pipe_mode && hold_done && !ras_release && !refresh_busy)
            |=> dram_addr == ADDR_W'(row_q));

    p_nopipe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_COL && !pipe_mode && !ras_release && !refresh_busy) |=> st == S_COL);

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_ROW || st == S_COL || st == S_REROW) && ras_release && !refresh_busy)
            |=> st == S_IDLE);

    p_rfsh_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && row_phase && refresh_busy) |=> (st == S_RFSH) && $stable(row_q));
endmodule

bind dram_addr_mux dam_checker #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_in       (row_in),
    .row_phase    (row_phase),
    .col_phase    (col_phase),
    .ras_release  (ras_release),
    .refresh_busy (refresh_busy),
    .col_step     (col_step),
    .pipe_mode    (pipe_mode),
    .hold_done    (hold_done),
    .st           (st_cur),
    .row_q        (row_q),
    .col_q        (col_q),
    .rfsh_row     (rfsh_row),
    .dram_addr    (dram_addr)
);

// File: tb/sim_dram_addr_mux.sv
module sim_dram_addr_mux;
    localparam int RW = 4;
    localparam int CW = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] row_in = '0;
    logic [CW-1:0] col_in = '0;
    logic          row_phase = 1'b0;
    logic          col_phase = 1'b0;
    logic          ras_release = 1'b0;
    logic          refresh_busy = 1'b0;
    logic          col_step = 1'b0;
    logic          pipe_mode = 1'b0;
    logic [AW-1:0] dram_addr;

    int n_vec = 0;
    int n_bad = 0;
    int exp_row = 0;
    int exp_col = 0;
    int exp_rf = 0;

    always #4 clk = ~clk;

    dram_addr_mux #(.ROW_W(RW), .COL_W(CW), .HOLD_CYC(1)) u0 (
        .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_in(col_in),
        .row_phase(row_phase), .col_phase(col_phase), .ras_release(ras_release),
        .refresh_busy(refresh_busy), .col_step(col_step), .pipe_mode(pipe_mode),
        .dram_addr(dram_addr)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int exp, input string req);
        n_vec++;
        if (int'(dram_addr) != exp) begin
            n_bad++;
            $display("FAIL %s: bus got %0d expected %0d", req, dram_addr, exp);
        end
    endtask

    task automatic refresh(input int ext, input int back, input string req);
        refresh_busy = 1'b1;
        cyc(); chk(exp_rf, req);
        cyc(); chk(exp_rf, "R4");
        refresh_busy = 1'b0;
        if (ext > 0) begin
            col_step = 1'b1;
            for (int k = 0; k < ext; k++) begin
                cyc(); chk(exp_rf, "R7 extend");
            end
            col_step = 1'b0;
        end
        cyc(); chk(back, "R12 resume");
        exp_rf = (exp_rf + 1) % 16;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        chk(0, "R1 reset bus");
        refresh(0, 0, "R1 refresh row 0");

        // Sweep every row/column pair in both modes.
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                pipe_mode = ((r + c) % 2) == 1;
                row_in = RW'(r); col_in = CW'(c); row_phase = 1'b1;
                cyc(); row_phase = 1'b0;
                exp_row = r; exp_col = c;
                chk(r, "R2");
                col_phase = 1'b1;
                cyc(); col_phase = 1'b0;
                chk(c, "R3");
                if (pipe_mode) begin
                    cyc(); chk(r, "R8 back to row");
                    if (c % 4 == 0) begin
                        col_step = 1'b1;
                        cyc(); col_step = 1'b0;
                        chk(r, "R6 row kept");
                        col_phase = 1'b1;
                        cyc(); col_phase = 1'b0;
                        exp_col = (exp_col + 1) % 16;
                        chk(exp_col, "R6 pipelined burst");
                        cyc(); chk(r, "R8");
                    end
                end else begin
                    cyc(); chk(c, "R9");
                    cyc(); chk(c, "R9");
                    if (c >= 13) begin
                        col_step = 1'b1;
                        for (int k = 0; k < 4; k++) begin
                            cyc();
                            exp_col = (exp_col + 1) % 16;
                            chk(exp_col, "R6 wrap");
                        end
                        col_step = 1'b0;
                        cyc(); chk(exp_col, "R9");
                    end
                    if (c == 6) refresh(2, exp_col, "R4 during column");
                end
                ras_release = 1'b1;
                cyc(); ras_release = 1'b0;
                chk(r, "R10");
            end
            refresh(r % 3, r, "R4 idle");
        end

        // Refresh wins over a simultaneous row phase.
        pipe_mode = 1'b0;
        row_in = 4'd9; col_in = 4'd9;
        row_phase = 1'b1; refresh_busy = 1'b1;
        cyc(); row_phase = 1'b0;
        chk(exp_rf, "R11 refresh wins");
        refresh_busy = 1'b0;
        cyc(); chk(exp_row, "R11 no access");
        exp_rf = (exp_rf + 1) % 16;

        // Refresh in the row phase resumes the row phase.
        row_in = 4'd3; col_in = 4'd12; row_phase = 1'b1;
        cyc(); row_phase = 1'b0;
        exp_row = 3;
        chk(3, "R2");
        refresh(1, 3, "R4 during row");
        col_phase = 1'b1;
        cyc(); col_phase = 1'b0;
        chk(12, "R12 column kept");
        ras_release = 1'b1;
        cyc(); ras_release = 1'b0;
        chk(3, "R10");

        // Counter wrap after further refreshes.
        for (int k = 0; k < 18; k++) refresh(0, 3, "R5 wrap");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule